// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block watches a host's parallel write bus: an address, a data byte and an active-low write strobe, all asynchronous to the system clock. It picks out the six-write erase command chain from that traffic. The chain is an unlock pair, then a set-up byte, then a second unlock pair, then a final erase byte. When the final byte names a sector erase, the block emits a one-cycle sector request together with the sector number. When the final byte names a whole-array erase, it emits a one-cycle chip request. A broken chain or a reset-command byte produces a one-cycle abort that sends the device back to read mode.

The strobe passes through a two-flop synchroniser, and both of its edges become single-cycle pulses. The address is sampled on the falling-edge pulse and the data byte on the rising-edge pulse. The host must therefore hold the data stable until a few clocks after it raises the strobe. The address only needs to be valid at the falling edge.

The outputs are plain control pulses. They have no back-pressure: each request is a single-cycle strobe that a downstream erase sequencer must capture. `sector_id` holds its value until the next sector request.

Top module: `erase_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, no request or abort is raised until a write completes. The decoder starts in its idle (read) state.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 followed by any address with data 0x30 raise `sector_erase_req` for one cycle. During that cycle `sector_id` equals address bits [13:11] of the final write. Only address bits [10:0] are compared on the unlock and set-up writes.
- R3: The same five leading writes followed by 0x555/0x10 raise `chip_erase_req` for one cycle. Data 0x10 at any other address is treated as a mismatch.
- R4: A write that does not match the expected step, in any step after the first, raises `abort` for one cycle and returns the decoder to idle. This includes a final byte other than 0x30 or a valid 0x10. A correct chain afterwards is decoded normally.
- R5: A write that does not match the first unlock step (other than 0xF0) is ignored. It raises nothing, and a correct chain that follows is decoded with exactly one request.
- R6: A write of data 0xF0, in any state including idle, raises `abort` for one cycle and returns the decoder to idle.
- R7: The address of a write is the value present when the falling strobe edge is detected. Later changes while the strobe is low have no effect.
- R8: The data of a write is the value present when the rising strobe edge is detected. Every output pulse comes one clock after a detected rising edge.
- R9: At most one of the three outputs is high in any cycle. Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Host write address; bits [13:11] select the sector |
| bus_data | input | 8 | Host write data byte |
| bus_wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| chip_erase_req | output | 1 | One-cycle whole-array erase request |
| sector_erase_req | output | 1 | One-cycle sector erase request |
| sector_id | output | 3 | Sector latched from the final write, valid with the request |
| abort | output | 1 | One-cycle return-to-read-mode pulse |

## Verification
A step counter that is off by one, or that misses its return to idle, shows up at the ports on the very next chain. Either a request comes one write too early, or an abort appears where a request was due, or a correct chain stops being decoded after a failed one. An address captured at the wrong edge shows as a wrong `sector_id` on the same request. Data taken at the falling edge shows up at once, because the bench drives a wrong byte until mid-strobe. The scoreboard compares every output pulse in order against the predicted event list. At the end it requires that no event is missing and that no pulse arrived unexpectedly.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] BYTE_UNLK_A = 8'hAA;
  localparam logic [DATA_W-1:0] BYTE_UNLK_B = 8'h55;
  localparam logic [DATA_W-1:0] BYTE_SETUP  = 8'h80;
  localparam logic [DATA_W-1:0] BYTE_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] BYTE_SECTOR = 8'h30;
  localparam logic [DATA_W-1:0] BYTE_RESET  = 8'hF0;

  localparam logic [11:0] LOC_A = 12'h555;
  localparam logic [11:0] LOC_B = 12'h2AA;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UNLK2 = 3'd1,
    ST_SETUP = 3'd2,
    ST_UNLK3 = 3'd3,
    ST_UNLK4 = 3'd4,
    ST_FINAL = 3'd5
  } step_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_p,
  output logic rise_p
);
  localparam int CHAIN = SYNC_N + 1;

  logic [CHAIN-1:0] chain_q;

  // synchroniser stages plus one history stage for edge detection
  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= strobe_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign fall_p = !chain_q[SYNC_N-1] &&  chain_q[SYNC_N];
  assign rise_p =  chain_q[SYNC_N-1] && !chain_q[SYNC_N];
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import erase_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              chip_req,
  output logic              sec_req,
  output logic [SEC_W-1:0]  sec_id,
  output logic              abort_p,
  output step_e             step_q
);
  localparam int LOW_W = ADDR_W - SEC_W;

  logic [ADDR_W-1:0] addr_q;
  logic [LOW_W-1:0]  low;
  logic              at_a, at_b;
  step_e             step_d;
  logic              hit_chip, hit_sec, miss;

  assign low  = addr_q[LOW_W-1:0];
  assign at_a = (low == LOW_W'(LOC_A));
  assign at_b = (low == LOW_W'(LOC_B));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      addr_q <= '0;
    else if (fall_p) addr_q <= addr;

  always_comb begin
    step_d   = step_q;
    hit_chip = 1'b0;
    hit_sec  = 1'b0;
    miss     = 1'b0;
    if (rise_p) begin
      if (data == BYTE_RESET) begin
        step_d = ST_IDLE;
        miss   = 1'b1;
      end else begin
        unique case (step_q)
          ST_IDLE:
            if (at_a && data == BYTE_UNLK_A) step_d = ST_UNLK2;
          ST_UNLK2:
            if (at_b && data == BYTE_UNLK_B) step_d = ST_SETUP;
            else begin step_d = ST_IDLE; miss = 1'b1; end
          ST_SETUP:
            if (at_a && data == BYTE_SETUP) step_d = ST_UNLK3;
            else begin step_d = ST_IDLE; miss = 1'b1; end
          ST_UNLK3:
            if (at_a && data == BYTE_UNLK_A) step_d = ST_UNLK4;
            else begin step_d = ST_IDLE; miss = 1'b1; end
          ST_UNLK4:
            if (at_b && data == BYTE_UNLK_B) step_d = ST_FINAL;
            else begin step_d = ST_IDLE; miss = 1'b1; end
          ST_FINAL: begin
            step_d = ST_IDLE;
            if (data == BYTE_SECTOR)           hit_sec  = 1'b1;
            else if (at_a && data == BYTE_CHIP) hit_chip = 1'b1;
            else                               miss     = 1'b1;
          end
          default: step_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      chip_req <= 1'b0;
      sec_req  <= 1'b0;
      abort_p  <= 1'b0;
      sec_id   <= '0;
    end else begin
      step_q   <= step_d;
      chip_req <= hit_chip;
      sec_req  <= hit_sec;
      abort_p  <= miss;
      if (hit_sec) sec_id <= addr_q[ADDR_W-1 -: SEC_W];
    end
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder #(
  parameter int ADDR_W = 14,
  parameter int SEC_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              bus_wr_n,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic [SEC_W-1:0]  sector_id,
  output logic              abort
);
  logic            fall_pulse, rise_pulse;
  erase_pkg::step_e step_q;

  strobe_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (bus_wr_n),
    .fall_p   (fall_pulse),
    .rise_p   (rise_pulse)
  );

  cmd_fsm #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_p   (fall_pulse),
    .rise_p   (rise_pulse),
    .addr     (bus_addr),
    .data     (bus_data),
    .chip_req (chip_erase_req),
    .sec_req  (sector_erase_req),
    .sec_id   (sector_id),
    .abort_p  (abort),
    .step_q   (step_q)
  );
endmodule

// File: rtl/erase_cmd_checker.sv
module erase_cmd_checker (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_req,
  input logic             sec_req,
  input logic             abort_p,
  input logic             rise_p,
  input erase_pkg::step_e step
);
  logic any_out;
  assign any_out = chip_req | sec_req | abort_p;

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!any_out); // R1

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({chip_req, sec_req, abort_p}) <= 1); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |=> !any_out); // R9

  AST_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(rise_p)); // R8

  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> step == erase_pkg::ST_IDLE); // R4
endmodule

bind erase_cmd_decoder erase_cmd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_req (chip_erase_req),
  .sec_req  (sector_erase_req),
  .abort_p  (abort),
  .rise_p   (rise_pulse),
  .step     (step_q)
);

// File: tb/tb_erase_cmd_decoder.sv
module tb_erase_cmd_decoder;
  localparam logic [1:0] EV_CHIP = 2'd1, EV_SEC = 2'd2, EV_ABT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_wr_n = 1'b1;
  logic        chip_erase_req, sector_erase_req, abort;
  logic [2:0]  sector_id;

  int total = 0;
  int bad = 0;
  logic [1:0] q_kind[$];
  logic [2:0] q_sec[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  erase_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr_n(bus_wr_n), .chip_erase_req(chip_erase_req),
    .sector_erase_req(sector_erase_req), .sector_id(sector_id), .abort(abort)
  );

  task automatic expect_ev(input logic [1:0] k, input logic [2:0] s, input string tag);
    q_kind.push_back(k); q_sec.push_back(s); q_tag.push_back(tag);
  endtask

  // one bus write; wrong data until mid-strobe (R8), optional address swap while low (R7)
  task automatic bus_wr(input logic [13:0] a, input logic [7:0] d,
                        input logic swap = 1'b0, input logic [13:0] a2 = '0);
    @(negedge clk);
    bus_addr = a; bus_data = ~d;
    @(negedge clk);
    bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    if (swap) bus_addr = a2;
    bus_data = d;
    repeat (2) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_data = ~d;
  endtask

  task automatic lead_in();
    bus_wr(14'h555, 8'hAA); bus_wr(14'h2AA, 8'h55); bus_wr(14'h555, 8'h80);
    bus_wr(14'h555, 8'hAA); bus_wr(14'h2AA, 8'h55);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (chip_erase_req || sector_erase_req || abort)) begin
      logic [1:0] k;
      k = chip_erase_req ? EV_CHIP : sector_erase_req ? EV_SEC : EV_ABT;
      total++;
      if (q_kind.size() == 0) begin
        bad++;
        $display("FAIL R5/R9 unexpected pulse kind=%0d (expected none)", k);
      end else begin
        logic [1:0] ek; logic [2:0] es; string et;
        ek = q_kind.pop_front(); es = q_sec.pop_front(); et = q_tag.pop_front();
        if (k != ek || (ek == EV_SEC && sector_id != es)) begin
          bad++;
          $display("FAIL %s kind=%0d sector=%0d expected kind=%0d sector=%0d",
                   et, k, sector_id, ek, es);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (chip_erase_req || sector_erase_req || abort) begin
      bad++; $display("FAIL R1 outputs=%b expected 000",
                      {chip_erase_req, sector_erase_req, abort});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (chip_erase_req || sector_erase_req || abort) begin
      bad++; $display("FAIL R1 after release outputs=%b expected 000",
                      {chip_erase_req, sector_erase_req, abort});
    end

    // R2: sector erase at sectors 5, 0, 7
    expect_ev(EV_SEC, 3'd5, "R2 sector 5");
    lead_in(); bus_wr({3'd5, 11'h123}, 8'h30);
    expect_ev(EV_SEC, 3'd0, "R2 sector 0");
    lead_in(); bus_wr({3'd0, 11'h000}, 8'h30);
    expect_ev(EV_SEC, 3'd7, "R2 sector 7");
    lead_in(); bus_wr({3'd7, 11'h7FF}, 8'h30);
    // R2: unlock compares only low bits
    expect_ev(EV_SEC, 3'd2, "R2 high bits on unlock");
    bus_wr({3'd6, 11'h555}, 8'hAA); bus_wr({3'd1, 11'h2AA}, 8'h55);
    bus_wr(14'h555, 8'h80); bus_wr(14'h555, 8'hAA); bus_wr(14'h2AA, 8'h55);
    bus_wr({3'd2, 11'h010}, 8'h30);

    // R3: chip erase, then 0x10 at wrong address
    expect_ev(EV_CHIP, 3'd0, "R3 chip erase");
    lead_in(); bus_wr(14'h555, 8'h10);
    expect_ev(EV_ABT, 3'd0, "R3 chip byte at wrong address");
    lead_in(); bus_wr(14'h556, 8'h10);

    // R4: mismatches at later steps
    expect_ev(EV_ABT, 3'd0, "R4 bad set-up byte");
    bus_wr(14'h555, 8'hAA); bus_wr(14'h2AA, 8'h55); bus_wr(14'h555, 8'h90);
    expect_ev(EV_CHIP, 3'd0, "R4 recovery chip");
    lead_in(); bus_wr(14'h555, 8'h10);
    expect_ev(EV_ABT, 3'd0, "R4 bad unlock address");
    bus_wr(14'h555, 8'hAA); bus_wr(14'h2AB, 8'h55);
    expect_ev(EV_ABT, 3'd0, "R4 unknown final byte");
    lead_in(); bus_wr(14'h555, 8'h20);

    // R5: first-step mismatch ignored
    expect_ev(EV_SEC, 3'd3, "R5 after ignored write");
    bus_wr(14'h555, 8'hAB); bus_wr(14'h2AA, 8'h55);
    lead_in(); bus_wr({3'd3, 11'h055}, 8'h30);

    // R6: reset byte mid-chain and in idle
    expect_ev(EV_ABT, 3'd0, "R6 reset byte mid-chain");
    bus_wr(14'h555, 8'hAA); bus_wr(14'h2AA, 8'h55); bus_wr(14'h555, 8'h80);
    bus_wr(14'h555, 8'hF0);
    expect_ev(EV_ABT, 3'd0, "R6 reset byte in idle");
    bus_wr(14'h000, 8'hF0);
    expect_ev(EV_SEC, 3'd4, "R6 chain works after reset byte");
    lead_in(); bus_wr({3'd4, 11'h300}, 8'h30);

    // R7: address changed while strobe low
    expect_ev(EV_SEC, 3'd6, "R7 address from falling edge");
    lead_in(); bus_wr({3'd6, 11'h111}, 8'h30, 1'b1, {3'd1, 11'h111});

    repeat (10) @(negedge clk);
    total++;
    if (q_kind.size() != 0) begin
      bad++;
      $display("FAIL R5 missing events actual=%0d expected=0 next=%s",
               q_kind.size(), q_tag[0]);
    end
    // R2: sector_id holds after request
    total++;
    if (sector_id != 3'd6) begin
      bad++; $display("FAIL R2 sector_id hold actual=%0d expected=6", sector_id);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule